// File: doc/BRIEF.md
# Reload Down-Counter Timer

A 16-bit down-counter with a byte-wide register port. Software loads a reload value into write-only buffer bytes, picks a count source in a control byte, and sets a run bit. Setting the run bit copies the buffers into the counter. From then on the counter decrements once per count enable. A count enable comes either from a power-of-two tap on the system clock or from a chosen edge of an external input. When a count enable finds the counter at zero, the block signals an underflow. It then either reloads from the buffers or, in one-shot mode, stops and clears the run bit.

Each underflow produces a one-cycle event pulse and flips a toggle flop. The toggle therefore runs at half the underflow rate, and it reaches a pin output only while a pin enable input is high. Reads of the two counter byte addresses return the live count, not the buffers. Everything runs on the system clock. The prescaler taps and the synchronised external edges become single-cycle enables.

Top module: `reload_down_timer`

## Requirements
- R1: After reset every readable register reads 0, the timer is stopped, the underflow pulse is low and the pin output is low.
- R2: Address 0 reads the counter low byte and address 1 reads the counter high byte. Writing addresses 0 and 1 updates only the reload buffer (bits 7:0 and 15:8) and does not alter the running count.
- R3: Address 2 is the control byte: bit 7 run, bit 6 one-shot, bit 5 falling-edge select, bits 2:0 source select. Writing bit 7 = 1 while stopped copies the buffer into the counter and starts counting. Writing bit 7 = 1 while already running neither preloads nor disturbs the count.
- R4: Writing bit 7 = 0 stops counting, and the counter then holds its value.
- R5: Select codes 0 to 3 count every 2^code system cycles. The prescaler phase restarts on preload, so the first decrement lands 2^code cycles after the starting write. With reload value V and one-shot clear, an underflow occurs every 2^code·(V+1) cycles and the counter reloads to V.
- R6: With one-shot set, the underflow leaves the counter at 0 and clears the run bit, so control reads bit 7 = 0. A later start preloads again.
- R7: Select code 4 counts edges of the external input after a two-flop synchroniser: rising edges when bit 5 = 0, falling edges when bit 5 = 1. A decrement appears two clock edges after the first edge at which the new input level is sampled.
- R8: Select codes 5 to 7 produce no count enable, so the counter holds while running. Control bits 4:3 always read 0.
- R9: Each underflow raises the underflow output for exactly the one cycle after the underflowing edge. A reload value of 0 underflows on every count enable.
- R10: Each underflow flips the toggle output. The pin output shows the toggle when the pin enable is 1 and is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address (0 low byte, 1 high byte, 2 control) |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i, combinational |
| ext_i | input | 1 | External count input, asynchronous |
| pin_en_i | input | 1 | Pin function enable for the toggle |
| uf_o | output | 1 | One-cycle underflow event |
| pin_o | output | 1 | Toggle output gated by pin_en_i |

## Verification
The bench builds the block with its default parameters: a 16-bit counter and four prescaler taps. The small tap count makes a full sweep practical. Every tap code is crossed with every reload value from 0 to 7, and the count, the underflow pulse and the toggle are predicted arithmetically and compared on every cycle for two full periods. The wide counter is reached through one directed reload that spans both bytes and borrows across the byte boundary. Directed runs then cover one-shot stop and restart, a repeated start, the idle select codes, and both external edge polarities including the exact synchroniser latency.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
package tmr_pkg;
  localparam int SEL_W        = 3;
  localparam int CTRL_RUN     = 7;
  localparam int CTRL_ONESHOT = 6;
  localparam int CTRL_FALL    = 5;

  typedef struct packed {
    logic             oneshot;
    logic             fall;
    logic [SEL_W-1:0] sel;
  } tmr_cfg_t;
endpackage

// File: rtl/tmr_regs.sv
`timescale 1ns/1ps
module tmr_regs
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int AW    = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [7:0]       wdata_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             stop_i,
  output logic [7:0]       rdata_o,
  output logic [CNT_W-1:0] reload_o,
  output tmr_cfg_t         cfg_o,
  output logic             run_o,
  output logic             load_o
);
  localparam int NB = CNT_W / 8;
  localparam logic [AW-1:0] CTRL_ADDR = AW'(NB);

  logic [7:0] rel_b [NB];
  logic       run_q;
  tmr_cfg_t   cfg_q;
  logic       ctrl_wr;

  assign ctrl_wr = wr_en_i && (addr_i == CTRL_ADDR);

  for (genvar g = 0; g < NB; g++) begin : g_rel
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) rel_b[g] <= '0;
      else if (wr_en_i && addr_i == AW'(g)) rel_b[g] <= wdata_i;
    end
    assign reload_o[g*8 +: 8] = rel_b[g];
  end

  // preload only on a 0->1 start
  assign load_o = ctrl_wr && wdata_i[CTRL_RUN] && !run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      cfg_q <= '0;
    end else begin
      if (stop_i)       run_q <= 1'b0;
      else if (ctrl_wr) run_q <= wdata_i[CTRL_RUN];
      if (ctrl_wr) begin
        cfg_q.oneshot <= wdata_i[CTRL_ONESHOT];
        cfg_q.fall    <= wdata_i[CTRL_FALL];
        cfg_q.sel     <= wdata_i[SEL_W-1:0];
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int b = 0; b < NB; b++)
      if (addr_i == AW'(b)) rdata_o = cnt_i[b*8 +: 8];
    if (addr_i == CTRL_ADDR)
      rdata_o = {run_q, cfg_q.oneshot, cfg_q.fall, 2'b00, cfg_q.sel};
  end

  assign cfg_o = cfg_q;
  assign run_o = run_q;
endmodule

// File: rtl/tmr_tick_gen.sv
`timescale 1ns/1ps
module tmr_tick_gen
  import tmr_pkg::*;
#(
  parameter int N_TAPS = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             load_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             fall_i,
  input  logic             ext_i,
  output logic             tick_o
);
  localparam int PW = (N_TAPS > 1) ? N_TAPS - 1 : 1;
  localparam logic [SEL_W-1:0] EXT_CODE = SEL_W'(N_TAPS);

  logic [PW-1:0]     pre_q;
  logic [2:0]        sync_q;
  logic [N_TAPS-1:0] tap_hit;
  logic              ext_rise, ext_fall;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pre_q <= '0;
    else if (load_i) pre_q <= '0;
    else if (run_i)  pre_q <= pre_q + PW'(1);
  end

  // [0],[1]: synchroniser, [2]: previous synced level
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[1:0], ext_i};
  end

  assign ext_rise = sync_q[1] & ~sync_q[2];
  assign ext_fall = ~sync_q[1] & sync_q[2];

  for (genvar t = 0; t < N_TAPS; t++) begin : g_tap
    localparam logic [PW-1:0] MASK = PW'((32'd1 << t) - 32'd1);
    assign tap_hit[t] = &(pre_q | ~MASK);
  end

  always_comb begin
    tick_o = 1'b0;
    if (run_i) begin
      for (int t = 0; t < N_TAPS; t++)
        if (sel_i == SEL_W'(t)) tick_o = tap_hit[t];
      if (sel_i == EXT_CODE) tick_o = fall_i ? ext_fall : ext_rise;
    end
  end
endmodule

// File: rtl/tmr_counter.sv
`timescale 1ns/1ps
module tmr_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             tick_i,
  input  logic             oneshot_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             uf_o,
  output logic             tog_o,
  output logic             stop_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             uf_q, tog_q, hit;

  assign hit    = tick_i && (cnt_q == '0);
  assign stop_o = hit && oneshot_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      uf_q  <= 1'b0;
      tog_q <= 1'b0;
    end else begin
      uf_q <= hit;
      if (hit) tog_q <= ~tog_q;
      if (load_i)      cnt_q <= reload_i;
      else if (hit)    cnt_q <= oneshot_i ? '0 : reload_i;
      else if (tick_i) cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  assign cnt_o = cnt_q;
  assign uf_o  = uf_q;
  assign tog_o = tog_q;
endmodule

// File: rtl/reload_down_timer.sv
`timescale 1ns/1ps
module reload_down_timer
  import tmr_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int N_TAPS = 4,
  localparam int AW    = $clog2(CNT_W / 8 + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [AW-1:0] addr_i,
  input  logic [7:0]    wdata_i,
  output logic [7:0]    rdata_o,
  input  logic          ext_i,
  input  logic          pin_en_i,
  output logic          uf_o,
  output logic          pin_o
);
  logic [CNT_W-1:0] cnt, reload;
  tmr_cfg_t         cfg;
  logic             run, load, tick, stop, tog, oneshot;

  assign oneshot = cfg.oneshot;

  tmr_regs #(.CNT_W(CNT_W), .AW(AW)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .addr_i, .wdata_i,
    .cnt_i(cnt), .stop_i(stop), .rdata_o,
    .reload_o(reload), .cfg_o(cfg), .run_o(run), .load_o(load)
  );

  tmr_tick_gen #(.N_TAPS(N_TAPS)) u_tick (
    .clk_i, .rst_ni, .run_i(run), .load_i(load),
    .sel_i(cfg.sel), .fall_i(cfg.fall), .ext_i, .tick_o(tick)
  );

  tmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i, .rst_ni, .load_i(load), .tick_i(tick), .oneshot_i(oneshot),
    .reload_i(reload), .cnt_o(cnt), .uf_o, .tog_o(tog), .stop_o(stop)
  );

  assign pin_o = pin_en_i & tog;
endmodule

// File: rtl/reload_down_timer_chk.sv
`timescale 1ns/1ps
module reload_down_timer_chk #(
  parameter int CNT_W = 16,
  parameter int AW    = 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_en_i,
  input logic [AW-1:0]    addr_i,
  input logic [7:0]       wdata_i,
  input logic             uf_o,
  input logic [CNT_W-1:0] cnt_q,
  input logic             run_q,
  input logic             tick,
  input logic             oneshot,
  input logic             tog_q
);
  localparam logic [AW-1:0] CTRL_ADDR = AW'(CNT_W / 8);
  logic start_wr;
  assign start_wr = wr_en_i && addr_i == CTRL_ADDR && wdata_i[7];

  a_r5_decrement: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && tick && cnt_q != '0) |=> cnt_q == $past(cnt_q) - CNT_W'(1));

  a_r9_uf_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uf_o |-> ($past(tick) && $past(cnt_q) == '0));

  a_r10_toggle_on_uf: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tog_q != $past(tog_q)) |-> uf_o);

  a_r4_hold_stopped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_q && !start_wr) |=> $stable(cnt_q));

  a_r3_restart_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && start_wr && !tick) |=> cnt_q == $past(cnt_q));

  a_r6_oneshot_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && oneshot && tick && cnt_q == '0) |=> (!run_q && cnt_q == '0));
endmodule

bind reload_down_timer reload_down_timer_chk #(.CNT_W(CNT_W), .AW(AW)) u_chk (
  .clk_i, .rst_ni, .wr_en_i, .addr_i, .wdata_i, .uf_o,
  .cnt_q(cnt), .run_q(run), .tick(tick), .oneshot(oneshot), .tog_q(tog)
);

// File: tb/reload_down_timer_tb.sv
`timescale 1ns/1ps
module reload_down_timer_tb;
  logic       clk = 1'b0, rst_ni = 1'b0;
  logic       wr_en_i = 1'b0, ext_i = 1'b0, pin_en_i = 1'b1;
  logic [1:0] addr_i = '0;
  logic [7:0] wdata_i = '0, rdata_o;
  logic       uf_o, pin_o;
  int n_vec = 0, n_bad = 0;
  logic exp_tog = 1'b0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  reload_down_timer u_dut (
    .clk_i(clk), .rst_ni, .wr_en_i, .addr_i, .wdata_i, .rdata_o,
    .ext_i, .pin_en_i, .uf_o, .pin_o
  );

  task automatic chk(input string req, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output int d);
    addr_i = a;
    #0.1;
    d = int'(rdata_o);
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic sweep(input int k, input int r);
    int d, t, ecnt, lim;
    bit euf;
    lim = 2 * (1 << k) * (r + 1) + 2;
    wr(2'd0, 8'(r)); wr(2'd1, 8'h00); wr(2'd2, 8'(8'h80 | k));
    for (int j = 0; j <= lim; j++) begin
      t = j >> k;
      ecnt = r - (t % (r + 1));
      euf = (j % (1 << k) == 0) && t > 0 && (t % (r + 1) == 0);
      if (euf) exp_tog = ~exp_tog;
      rd(2'd0, d);
      chk($sformatf("R5 cnt k=%0d v=%0d j=%0d", k, r, j), d, ecnt);
      chk($sformatf("R9 uf k=%0d v=%0d j=%0d", k, r, j), int'(uf_o), int'(euf));
      chk($sformatf("R10 pin k=%0d v=%0d j=%0d", k, r, j), int'(pin_o), int'(exp_tog));
      if (j == lim) wr(2'd2, 8'h00); else @(negedge clk);
    end
    // the stop write edge still counts
    t = (lim + 1) >> k;
    ecnt = r - (t % (r + 1));
    if (((lim + 1) % (1 << k) == 0) && (t % (r + 1) == 0)) exp_tog = ~exp_tog;
    cyc(3);
    rd(2'd0, d);
    chk("R4 hold after stop", d, ecnt);
  endtask

  initial begin
    int d;
    rd(2'd0, d);
    #12 rst_ni = 1'b1;
    @(negedge clk);
    // R1
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), d);
      chk($sformatf("R1 reset addr %0d", a), d, 0);
    end
    chk("R1 reset uf", int'(uf_o), 0);
    chk("R1 reset pin", int'(pin_o), 0);

    for (int k = 0; k < 4; k++)
      for (int r = 0; r < 8; r++) sweep(k, r);

    // R2 two-byte count, buffer write does not disturb
    wr(2'd0, 8'h02); wr(2'd1, 8'h01); wr(2'd2, 8'h80);
    rd(2'd0, d); chk("R2 low byte after preload", d, 8'h02);
    rd(2'd1, d); chk("R2 high byte after preload", d, 8'h01);
    cyc(3);
    rd(2'd0, d); chk("R2 low byte borrow", d, 8'hFF);
    rd(2'd1, d); chk("R2 high byte borrow", d, 8'h00);
    wr(2'd0, 8'h05); // count at edge: 0x00FE
    rd(2'd0, d); chk("R2 buffer write ignored by count", d, 8'hFE);
    wr(2'd1, 8'h00);
    rd(2'd1, d); chk("R2 high buffer write ignored", d, 8'h00);
    // R3 repeated start: one decrement, no preload
    wr(2'd2, 8'h80);
    rd(2'd0, d); chk("R3 restart ignored", d, 8'hFC);
    wr(2'd2, 8'h00);

    // R6 one-shot, reload 3
    wr(2'd0, 8'h03); wr(2'd1, 8'h00); wr(2'd2, 8'hC0);
    for (int j = 0; j <= 8; j++) begin
      bit euf;
      euf = (j == 4);
      if (euf) exp_tog = ~exp_tog;
      rd(2'd0, d);
      chk($sformatf("R6 cnt j=%0d", j), d, (j < 4) ? 3 - j : 0);
      chk($sformatf("R9 oneshot uf j=%0d", j), int'(uf_o), int'(euf));
      if (j >= 4) begin
        rd(2'd2, d);
        chk($sformatf("R6 run cleared j=%0d", j), d, 8'h40);
      end
      @(negedge clk);
    end
    wr(2'd2, 8'hC0);
    rd(2'd0, d); chk("R6 restart preloads", d, 3);
    wr(2'd2, 8'h00);

    // R10 pin gating
    pin_en_i = 1'b0; #0.1;
    chk("R10 pin gated off", int'(pin_o), 0);
    pin_en_i = 1'b1; #0.1;
    chk("R10 pin follows toggle", int'(pin_o), int'(exp_tog));

    // R8 idle codes and reserved bits
    wr(2'd0, 8'h09);
    wr(2'd2, 8'h85);
    cyc(5);
    rd(2'd0, d); chk("R8 code 5 holds", d, 9);
    wr(2'd2, 8'h00);
    wr(2'd2, 8'hFF);
    rd(2'd2, d); chk("R8 ctrl readback", d, 8'hE7);
    cyc(5);
    rd(2'd0, d); chk("R8 code 7 holds", d, 9);
    chk("R8 no uf", int'(uf_o), 0);
    wr(2'd2, 8'h00);

    // R7 rising edges, reload 10
    wr(2'd0, 8'h0A);
    wr(2'd2, 8'h84);
    ext_i = 1'b1;
    cyc(2);
    rd(2'd0, d); chk("R7 latency not yet", d, 10);
    cyc(1);
    rd(2'd0, d); chk("R7 latency decrement", d, 9);
    cyc(3);
    rd(2'd0, d); chk("R7 high level counts once", d, 9);
    ext_i = 1'b0; cyc(3);
    for (int p = 0; p < 3; p++) begin
      ext_i = 1'b1; cyc(3); ext_i = 1'b0; cyc(3);
    end
    cyc(2);
    rd(2'd0, d); chk("R7 rising count", d, 6);
    wr(2'd2, 8'h00);

    // R7 falling edges
    wr(2'd2, 8'hA4);
    ext_i = 1'b1; cyc(5);
    rd(2'd0, d); chk("R7 rise ignored in falling mode", d, 10);
    ext_i = 1'b0; cyc(3);
    for (int p = 0; p < 3; p++) begin
      ext_i = 1'b1; cyc(3); ext_i = 1'b0; cyc(3);
    end
    cyc(2);
    rd(2'd0, d); chk("R7 falling count", d, 6);
    wr(2'd2, 8'h00);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule